// File: doc/BRIEF.md
# Completion Response Queue with Read Port

This block holds completion responses from a DMA engine, one per finished descriptor, until a host collects them. Each response has two parts: the number of bytes that were actually moved, and a status word. The status word carries eight error bits and a flag that marks early termination. The host reads the two parts as separate 32-bit words on a small memory-mapped read port. The read of the status word removes the entry. A read of the byte-count word only observes the entry and leaves it in place.

The block also drives a fill-level word and empty and full flags for a neighbouring control block. A response that arrives while the queue is full is discarded, and a sticky overflow flag records the loss. This flag clears only on reset.

Two state machines set the behaviour:

- **Occupancy machine.** Its states are `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. Its transitions are:
  - FILL_FIRST: from empty to partial, on a push with no pop.
  - FILL_LAST: from partial to full, on a push with no pop that reaches the depth.
  - DRAIN_FIRST: from full to partial, on a pop with no push.
  - DRAIN_LAST: from partial to empty, on a pop with no push that leaves zero entries.
  - HOLD: any other cycle keeps the current state.
- **Read answer machine.** Its states are `RD_IDLE` and `RD_ANSWER`.
  - ACCEPT: it enters `RD_ANSWER` on every cycle that has a read request.
  - RELEASE: it returns to `RD_IDLE` on a cycle without a request.
  - `rd_valid` is high exactly while the machine is in `RD_ANSWER`.

Top module: `rsp_fifo_port`

## Requirements
- R1: After reset `fifo_empty`=1, `fifo_full`=0, `fifo_overflow`=0, `level_word`=0 and `rd_valid`=0.
- R2: A read request at byte offset 0x0 is answered on the cycle after the request is sampled. `rd_valid`=1 and `rd_data` equals the head entry's byte count. The entry stays queued and the level does not change.
- R3: A read at byte offset 0x4 answers with the head status word on the next cycle. The word has the error bits in [7:0], the early-termination flag in bit 8 and zeros above. The same read removes the head entry, so the level drops by one.
- R4: Entries leave in the order in which they were accepted.
- R5: A read while the queue is empty answers zero and does not change the level or the flags.
- R6: A push while full with no pop in the same cycle is discarded and sets `fifo_overflow`. The flag stays at 1 until reset.
- R7: A push together with an effective pop leaves the level unchanged. This includes a full queue, where the push is then accepted. A pop on an empty queue is not effective, so a push in that cycle raises the level by one.
- R8: `level_word` bits [15:0] carry the entry count and bits [31:16] read zero. `fifo_empty` is 1 exactly when the count is 0. `fifo_full` is 1 exactly when the count equals DEPTH.
- R9: A read at any offset other than 0x0 and 0x4 (for example 0x8 or 0xC) answers zero and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_push | input | 1 | Offers one completion response |
| rsp_bytes | input | 32 | Bytes transferred for the response |
| rsp_err | input | 8 | Error bits of the response |
| rsp_early | input | 1 | Early-termination flag of the response |
| rd_en | input | 1 | Read request on the host port |
| rd_addr | input | 4 | Byte offset of the read |
| rd_valid | output | 1 | Read answer present |
| rd_data | output | 32 | Read answer word |
| level_word | output | 32 | Entry count, zero-extended |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_overflow | output | 1 | Sticky: a response was discarded |

## Verification
The hardest case to reach from the ports is a cycle in which a push and a status-word read arrive together while the queue is exactly full. In that cycle the pop frees a slot, so the push must be accepted and must not count as an overflow. The stimulus fills the queue to its depth and then sends one more push to set the sticky flag. It then issues a combined push and status read in a single cycle, and drains the queue in pairs of reads. The drain shows that the discarded entry never appears and that the entry pushed on the full cycle comes out last. The mirrored case is a combined push and pop on an empty queue. There the pop is not effective, so the push must raise the level to one.

// File: rtl/rsp_fifo_pkg.sv
package rsp_fifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_state_t;

    typedef enum logic {
        RD_IDLE,
        RD_ANSWER
    } rd_state_t;

    // Byte offsets decoded by the host read port.
    localparam int OFFS_COUNT  = 0;
    localparam int OFFS_STATUS = 4;

endpackage

// File: rtl/rsp_store.sv
module rsp_store #(
    parameter int DEPTH   = 8,
    parameter int ENTRY_W = 41
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic               rd_pop,
    output logic [ENTRY_W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PW-1:0]      wp_q;
    logic [PW-1:0]      rp_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wp_q] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_en)  wp_q <= step(wp_q);
            if (rd_pop) rp_q <= step(rp_q);
        end
    end

    assign head = mem[rp_q];

endmodule

// File: rtl/rsp_level.sv
module rsp_level
    import rsp_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output logic          is_empty,
    output logic          is_full,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);

    occ_state_t    occ_q, occ_d;
    logic [CW-1:0] count_q, count_d;
    logic          ovf_q;

    // Acceptance: a pop needs an entry; a push needs room, or a pop in the same cycle.
    always_comb begin
        pop_ok  = pop_req && (occ_q != OCC_EMPTY);
        push_ok = push_req && ((occ_q != OCC_FULL) || pop_ok);
    end

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   count_d = count_q + ONE;
            2'b01:   count_d = count_q - ONE;
            default: count_d = count_q;
        endcase
    end

    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (push_ok && !pop_ok)                                  // FILL_FIRST
                    occ_d = (DEPTH == 1) ? OCC_FULL : OCC_PART;
            end
            OCC_PART: begin
                if (push_ok && !pop_ok && count_q == FULL_CNT - ONE)     // FILL_LAST
                    occ_d = OCC_FULL;
                else if (pop_ok && !push_ok && count_q == ONE)           // DRAIN_LAST
                    occ_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop_ok && !push_ok)                                  // DRAIN_FIRST
                    occ_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PART;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q   <= OCC_EMPTY;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            occ_q   <= occ_d;
            count_q <= count_d;
            if (push_req && !push_ok) ovf_q <= 1'b1;
        end
    end

    always_comb begin
        is_empty = (occ_q == OCC_EMPTY);
        is_full  = (occ_q == OCC_FULL);
        count    = count_q;
        ovf      = ovf_q;
    end

    a_r8_empty_iff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty == (count_q == '0));

    a_r8_full_iff_depth: assert property (@(posedge clk) disable iff (!rst_n)
        is_full == (count_q == FULL_CNT));

    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_req && !pop_req) |=> (count_q == FULL_CNT && ovf_q));

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    a_r7_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count_q));

    a_r5_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop_req && !push_req) |=> is_empty);

endmodule

// File: rtl/rsp_read_port.sv
module rsp_read_port
    import rsp_fifo_pkg::*;
#(
    parameter int BYTE_W = 32,
    parameter int ERR_W  = 8,
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] head_bytes,
    input  logic [ERR_W-1:0]  head_err,
    input  logic              head_early,
    input  logic              fifo_empty,
    output logic              pop_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    rd_state_t         st_q, st_d;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] word_d;
    logic              sel_count;
    logic              sel_stat;

    always_comb begin
        sel_count = (rd_addr == AW'(OFFS_COUNT));
        sel_stat  = (rd_addr == AW'(OFFS_STATUS));
        pop_req   = rd_en && sel_stat;
        if (fifo_empty)
            word_d = '0;
        else if (sel_count)
            word_d = DATA_W'(head_bytes);
        else if (sel_stat)
            word_d = DATA_W'({head_early, head_err});
        else
            word_d = '0;
    end

    always_comb begin
        unique case (st_q)
            RD_IDLE:   st_d = rd_en ? RD_ANSWER : RD_IDLE;   // ACCEPT
            RD_ANSWER: st_d = rd_en ? RD_ANSWER : RD_IDLE;   // RELEASE
            default:   st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RD_IDLE;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            data_q <= rd_en ? word_d : '0;
        end
    end

    always_comb begin
        rd_valid = (st_q == RD_ANSWER);
        rd_data  = data_q;
    end

    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fifo_empty) |=> (rd_data == '0));

endmodule

// File: rtl/rsp_fifo_port.sv
module rsp_fifo_port #(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 32,
    parameter int ERR_W  = 8,
    parameter int DATA_W = 32,
    parameter int AW     = 4,
    parameter int LVL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_push,
    input  logic [BYTE_W-1:0] rsp_bytes,
    input  logic [ERR_W-1:0]  rsp_err,
    input  logic              rsp_early,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] level_word,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_overflow
);
    localparam int ENTRY_W = BYTE_W + ERR_W + 1;
    localparam int CW      = $clog2(DEPTH + 1);

    logic               push_ok;
    logic               pop_ok;
    logic               pop_req;
    logic [CW-1:0]      count;
    logic [ENTRY_W-1:0] head;
    logic [LVL_W-1:0]   lvl;

    rsp_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (rsp_push),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .count    (count),
        .is_empty (fifo_empty),
        .is_full  (fifo_full),
        .ovf      (fifo_overflow)
    );

    rsp_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_ok),
        .wr_entry ({rsp_early, rsp_err, rsp_bytes}),
        .rd_pop   (pop_ok),
        .head     (head)
    );

    rsp_read_port #(
        .BYTE_W (BYTE_W),
        .ERR_W  (ERR_W),
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .head_bytes (head[BYTE_W-1:0]),
        .head_err   (head[BYTE_W+ERR_W-1:BYTE_W]),
        .head_early (head[ENTRY_W-1]),
        .fifo_empty (fifo_empty),
        .pop_req    (pop_req),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign lvl        = LVL_W'(count);
    assign level_word = DATA_W'(lvl);

    a_r8_level_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        level_word[DATA_W-1:LVL_W] == '0);

    a_r3_status_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == AW'(4) && !fifo_empty && !rsp_push)
            |=> (level_word == $past(level_word) - DATA_W'(1)));

endmodule

// File: tb/tb_rsp_fifo_port.sv
`timescale 1ns/1ps
module tb_rsp_fifo_port;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rsp_push;
    logic [31:0] rsp_bytes;
    logic [7:0]  rsp_err;
    logic        rsp_early;
    logic        rd_en;
    logic [3:0]  rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] level_word;
    logic        fifo_empty;
    logic        fifo_full;
    logic        fifo_overflow;

    always #4 clk = ~clk;

    rsp_fifo_port #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rsp_push(rsp_push), .rsp_bytes(rsp_bytes),
        .rsp_err(rsp_err), .rsp_early(rsp_early), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .level_word(level_word),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_overflow(fifo_overflow)
    );

    typedef struct {
        logic [31:0] b;
        logic [31:0] s;
    } ent_t;

    ent_t        model[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          model_ovf = 1'b0;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model side of a read: returns the expected answer, pops on the status offset.
    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] v;
        v = '0;
        if (model.size() != 0) begin
            if (a == 4'h0) v = model[0].b;
            else if (a == 4'h4) begin
                v = model[0].s;
                void'(model.pop_front());
            end
        end
        return v;
    endfunction

    function automatic void model_push(input logic [31:0] b, input logic [7:0] e, input logic er);
        ent_t n;
        n.b = b;
        n.s = {23'b0, er, e};
        if (model.size() < DEPTH) model.push_back(n);
        else model_ovf = 1'b1;
    endfunction

    // All driver tasks start and end at a falling edge.
    task automatic push_rsp(input logic [31:0] b, input logic [7:0] e, input logic er);
        model_push(b, e, er);
        rsp_push = 1'b1; rsp_bytes = b; rsp_err = e; rsp_early = er;
        @(negedge clk);
        rsp_push = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic both(input logic [31:0] b, input logic [7:0] e, input logic er,
                        input logic [3:0] a, input string tag);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        model_push(b, e, er);
        rsp_push = 1'b1; rsp_bytes = b; rsp_err = e; rsp_early = er;
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rsp_push = 1'b0; rd_en = 1'b0;
    endtask

    task automatic chk_state(input string tag);
        check({tag, " level"},    level_word, 32'(model.size()));
        check({tag, " empty"},    32'(fifo_empty), 32'(model.size() == 0));
        check({tag, " full"},     32'(fifo_full), 32'(model.size() == DEPTH));
        check({tag, " overflow"}, 32'(fifo_overflow), 32'(model_ovf));
    endtask

    // Monitor: compares each read answer against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected answer", 32'd1, 32'd0);
            end else begin
                check({tag_q.pop_front(), " rd_data"}, rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rsp_push = 1'b0; rsp_bytes = '0; rsp_err = '0; rsp_early = 1'b0;
        rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_state("R1");
        check("R1 rd_valid", 32'(rd_valid), 32'd0);

        // R5: reads on an empty queue
        rd(4'h4, "R5");
        rd(4'h0, "R5");
        chk_state("R5");

        // R8: level after three pushes
        push_rsp(32'h0000_0100, 8'h00, 1'b0);
        push_rsp(32'h0000_002A, 8'h05, 1'b1);
        push_rsp(32'hFFFF_FFFF, 8'hFF, 1'b0);
        chk_state("R8");

        // R2: count reads do not pop
        rd(4'h0, "R2");
        rd(4'h0, "R2");
        chk_state("R2");

        // R9: other offsets answer zero
        rd(4'h8, "R9");
        rd(4'hC, "R9");
        chk_state("R9");

        // R3: status read pops
        rd(4'h4, "R3");
        chk_state("R3");

        // R4: remaining entries in order
        rd(4'h0, "R4"); rd(4'h4, "R4");
        rd(4'h0, "R4"); rd(4'h4, "R4");
        chk_state("R4");

        // R8: fill to depth
        for (int i = 0; i < DEPTH; i++) begin
            push_rsp(32'h0000_1000 + 32'(i), 8'(i * 3), i[0]);
        end
        chk_state("R8 full");

        // R6: push on full is dropped
        push_rsp(32'h0000_DEAD, 8'hEE, 1'b1);
        chk_state("R6");

        // R7: push with status read while full
        both(32'h0000_5555, 8'h11, 1'b1, 4'h4, "R7");
        chk_state("R7 full");

        // R4 and R6: drain, the dropped entry never appears
        for (int i = 0; i < DEPTH; i++) begin
            rd(4'h0, "R4");
            rd(4'h4, "R4");
        end
        chk_state("R6 sticky");

        // R7: push with pop at a middle level
        push_rsp(32'h0000_0777, 8'h42, 1'b0);
        both(32'h0000_0888, 8'h24, 1'b1, 4'h4, "R7");
        chk_state("R7 mid");
        rd(4'h0, "R7"); rd(4'h4, "R7");

        // R7: pop on empty is not effective, push counts
        both(32'h0000_0999, 8'h80, 1'b0, 4'h4, "R7");
        chk_state("R7 empty");
        rd(4'h0, "R4"); rd(4'h4, "R4");
        chk_state("R5 end");

        repeat (3) @(negedge clk);
        check("R2 all answers seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule